// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block takes parallel left/right audio samples and sends them out one bit at a time on a serial data line. It works as a slave: an external bit clock and an external left/right (frame) clock set the timing, and the block samples both with its own system clock. It detects each falling bit-clock edge itself and changes the data line only at those edges, so a receiver can take each bit on the following rising edge.

Five framings are available. Three are stereo framings in which the level of the left/right clock tells which channel is being sent: left justified, right justified and a one-bit-delayed stereo framing as used by I2S. The other two are DSP framings, where a rising edge on the frame clock starts a frame that holds the left word and then the right word with no gap between them. The word length can be 16, 20, 24 or 32 bits. Sample pairs are loaded with a ready/valid handshake into a one-pair holding register. If no new pair is waiting when a frame starts, the previous pair is sent again and a sticky underrun flag is set. A second sticky flag reports left/right clock periods that are too short for the selected word length.

Top module: `aud_tx_top`

## Requirements
- R1: After reset, sdataOut is 0, sampleReady is 1, and underrunFlag and shortFlag are 0.
- R2: A pair is accepted in a cycle where sampleValid and sampleReady are both 1. sampleReady then stays 0 until the next frame start, which is a falling bit-clock edge at which lrclkIn has gone from 0 to 1. At that frame start the accepted pair becomes the pair being sent.
- R3: In left justified mode (cfgFmt 0), the MSB is driven at the falling bit-clock edge where lrclkIn changes. The left word is sent while lrclkIn is 1 and the right word while it is 0. Bits after the LSB are 0.
- R4: In I2S mode (cfgFmt 1), the MSB comes one bit clock after the lrclkIn change. The channel choice and the zero fill are the same as in R3.
- R5: In right justified mode (cfgFmt 2), the LSB occupies the last bit clock before the next lrclkIn change. The half length used is the length of the previous lrclkIn level, counted in bit clocks. Bits before the MSB are 0.
- R6: In DSP mode B (cfgFmt 4), the left MSB is driven at the falling edge where lrclkIn rises. The right word follows the left LSB at once, and the frame is zero-filled after that.
- R7: In DSP mode A (cfgFmt 3), the bit layout is that of R6 delayed by one bit clock.
- R8: cfgWlen 0/1/2/3 selects 16/20/24/32 bits. The sample is taken from bits [W-1:0] of the input word and is sent MSB first.
- R9: Right justified mode with a 32-bit word is not allowed. In that setting sdataOut stays 0.
- R10: If a frame starts with no pair waiting, the previous pair is sent again and underrunFlag is set. underrunFlag stays 1 until reset.
- R11: shortFlag is set when a stereo lrclkIn level lasts fewer than W bit clocks, or when a DSP frame lasts fewer than 2W bit clocks. The first period after reset is exempt. shortFlag stays 1 until reset.
- R12: sdataOut changes only in the system-clock cycle after a detected falling bit-clock edge. It stays stable while the bit clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgFmt | input | 3 | Framing: 0 left justified, 1 I2S, 2 right justified, 3 DSP A, 4 DSP B |
| cfgWlen | input | 2 | Word length code: 16/20/24/32 bits |
| bclkIn | input | 1 | External bit clock |
| lrclkIn | input | 1 | External left/right or frame-sync clock |
| sampleL | input | 32 | Left sample, right-aligned |
| sampleR | input | 32 | Right sample, right-aligned |
| sampleValid | input | 1 | Sample pair offered |
| sampleReady | output | 1 | Holding register empty |
| sdataOut | output | 1 | Serial data out |
| underrunFlag | output | 1 | Sticky: a frame started with no fresh pair |
| shortFlag | output | 1 | Sticky: a left/right period was too short |

## Verification
Right justified mode is the hardest case to reach. Its bit positions depend on a half length that was measured in the previous level of the left/right clock, so a correct check needs two halves of the same length back to back. The bench runs an unchecked warm-up frame whenever the framing or the lengths change, and only then compares bit by bit. Underrun and short periods are set up by directed sequences: one frame leaves the holding register empty, and a short frame is followed by a normal one so that the length is measured.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  typedef enum logic [2:0] {
    FMT_LJ   = 3'd0,
    FMT_I2S  = 3'd1,
    FMT_RJ   = 3'd2,
    FMT_DSPA = 3'd3,
    FMT_DSPB = 3'd4
  } fmtE;

  localparam int unsigned POS_W = 5;

  typedef struct packed {
    logic             fallEv;
    logic             loadPair;
    logic             active;
    logic             selRight;
    logic [POS_W-1:0] bitPos;
  } txStrobeT;

  function automatic logic [5:0] wordLen(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/aud_tx_ctrl.sv
module aud_tx_ctrl
  import aud_tx_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cfgFmt,
  input  logic [1:0] cfgWlen,
  input  logic       bclkIn,
  input  logic       lrclkIn,
  output txStrobeT   strb,
  output logic       shortFlag
);

  localparam int unsigned EW = CNT_W + 1;

  logic [SYNC_LEN-1:0] bSh, lrSh;
  logic                bS, lrS, bDly, lrLast, seen;
  logic [CNT_W-1:0]    kCnt, kNext;
  logic [EW-1:0]       hLen, hUse, wb, need, periodLen, offset, kExt, jIdx, jw, limit;
  logic                isDsp, fallEv, anchor, lrRise, lrChg, fmtOk, rjOk, inWin;
  fmtE                 fmt;

  assign fmt = fmtE'(cfgFmt);
  assign bS  = bSh[SYNC_LEN-1];
  assign lrS = lrSh[SYNC_LEN-1];

  // input synchronisers for the external clocks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSh  <= '0;
      lrSh <= '0;
    end else begin
      bSh[0]  <= bclkIn;
      lrSh[0] <= lrclkIn;
      for (int i = 1; i < SYNC_LEN; i++) begin
        bSh[i]  <= bSh[i-1];
        lrSh[i] <= lrSh[i-1];
      end
    end
  end

  always_comb begin
    isDsp     = (fmt == FMT_DSPA) || (fmt == FMT_DSPB);
    fallEv    = bDly & ~bS;
    lrRise    = lrS & ~lrLast;
    lrChg     = lrS ^ lrLast;
    anchor    = fallEv & (isDsp ? lrRise : lrChg);
    kNext     = anchor ? '0 : ((&kCnt) ? kCnt : kCnt + CNT_W'(1));
    wb        = EW'(wordLen(cfgWlen));
    need      = isDsp ? (wb << 1) : wb;
    periodLen = {1'b0, kCnt} + EW'(1);
    hUse      = (anchor && !isDsp) ? periodLen : hLen;
    rjOk      = (cfgWlen != 2'd3) && (hUse >= wb);
    fmtOk     = 1'b1;
    case (fmt)
      FMT_LJ, FMT_DSPB:  offset = '0;
      FMT_I2S, FMT_DSPA: offset = EW'(1);
      FMT_RJ: begin
        offset = hUse - wb;
        fmtOk  = rjOk;
      end
      default: begin
        offset = '0;
        fmtOk  = 1'b0;
      end
    endcase
    kExt  = {1'b0, kNext};
    jIdx  = kExt - offset;
    limit = isDsp ? (wb << 1) : wb;
    inWin = fmtOk && (kExt >= offset) && (jIdx < limit);
    jw    = (isDsp && jIdx >= wb) ? jIdx - wb : jIdx;

    strb.fallEv   = fallEv;
    strb.loadPair = fallEv & lrRise;
    strb.active   = inWin;
    strb.selRight = isDsp ? (jIdx >= wb) : ~lrS;
    strb.bitPos   = POS_W'(wb - EW'(1) - jw);
  end

  // frame position counter, half-length measurement, period check
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bDly      <= 1'b0;
      lrLast    <= 1'b0;
      kCnt      <= '0;
      hLen      <= '0;
      seen      <= 1'b0;
      shortFlag <= 1'b0;
    end else begin
      bDly <= bS;
      if (fallEv) begin
        lrLast <= lrS;
        kCnt   <= kNext;
        if (anchor) begin
          seen <= 1'b1;
          if (!isDsp) hLen <= periodLen;
          if (seen && (periodLen < need)) shortFlag <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/aud_tx_dp.sv
module aud_tx_dp
  import aud_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobeT            strb,
  input  logic [SAMPLE_W-1:0] sampleL,
  input  logic [SAMPLE_W-1:0] sampleR,
  input  logic                sampleValid,
  output logic                sampleReady,
  output logic                sdataOut,
  output logic                underrunFlag
);

  logic [SAMPLE_W-1:0] pendL, pendR, curL, curR, nextL, nextR, word;
  logic                pendValid, accept, takePend;

  assign sampleReady = ~pendValid;
  assign accept      = sampleValid & ~pendValid;
  assign takePend    = strb.loadPair & pendValid;

  always_comb begin
    nextL = takePend ? pendL : curL;
    nextR = takePend ? pendR : curR;
    word  = strb.selRight ? nextR : nextL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendL        <= '0;
      pendR        <= '0;
      pendValid    <= 1'b0;
      curL         <= '0;
      curR         <= '0;
      sdataOut     <= 1'b0;
      underrunFlag <= 1'b0;
    end else begin
      if (strb.loadPair) begin
        if (pendValid) pendValid    <= 1'b0;
        else           underrunFlag <= 1'b1;
      end
      if (accept) begin
        pendL     <= sampleL;
        pendR     <= sampleR;
        pendValid <= 1'b1;
      end
      curL <= nextL;
      curR <= nextR;
      if (strb.fallEv) sdataOut <= strb.active ? word[strb.bitPos] : 1'b0;
    end
  end

endmodule

// File: rtl/aud_tx_top.sv
module aud_tx_top
  import aud_tx_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  cfgFmt,
  input  logic [1:0]  cfgWlen,
  input  logic        bclkIn,
  input  logic        lrclkIn,
  input  logic [31:0] sampleL,
  input  logic [31:0] sampleR,
  input  logic        sampleValid,
  output logic        sampleReady,
  output logic        sdataOut,
  output logic        underrunFlag,
  output logic        shortFlag
);

  txStrobeT strb;

  aud_tx_ctrl #(.CNT_W(CNT_W), .SYNC_LEN(SYNC_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgFmt(cfgFmt), .cfgWlen(cfgWlen),
    .bclkIn(bclkIn), .lrclkIn(lrclkIn), .strb(strb), .shortFlag(shortFlag)
  );

  aud_tx_dp #(.SAMPLE_W(32)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleL(sampleL), .sampleR(sampleR),
    .sampleValid(sampleValid), .sampleReady(sampleReady),
    .sdataOut(sdataOut), .underrunFlag(underrunFlag)
  );

endmodule

// File: rtl/aud_tx_chk.sv
module aud_tx_chk
  import aud_tx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [2:0] cfgFmt,
  input logic [1:0] cfgWlen,
  input logic       sampleValid,
  input logic       sampleReady,
  input logic       sdataOut,
  input logic       underrunFlag,
  input logic       shortFlag,
  input txStrobeT   strb
);

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleReady) |=> !sampleReady);

  p_load_frees_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadPair && !sampleReady) |=> sampleReady);

  p_fill_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fallEv && !strb.active) |=> !sdataOut);

  p_rj32_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fallEv && cfgFmt == 3'd2 && cfgWlen == 2'd3) |=> !sdataOut);

  p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    underrunFlag |=> underrunFlag);

  p_underrun_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrunFlag) |-> $past(strb.loadPair && sampleReady));

  p_short_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    shortFlag |=> shortFlag);

  p_change_on_fall_r12: assert property (@(posedge clk) disable iff (!rstN)
    (sdataOut != $past(sdataOut)) |-> $past(strb.fallEv));

endmodule

bind aud_tx_top aud_tx_chk chk_i (
  .clk(clk), .rstN(rstN), .cfgFmt(cfgFmt), .cfgWlen(cfgWlen),
  .sampleValid(sampleValid), .sampleReady(sampleReady), .sdataOut(sdataOut),
  .underrunFlag(underrunFlag), .shortFlag(shortFlag), .strb(strb)
);

// File: tb/aud_tx_top_tb_top.sv
module aud_tx_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgFmt = 3'd0;
  logic [1:0]  cfgWlen = 2'd0;
  logic        bclkIn = 1'b1;
  logic        lrclkIn = 1'b0;
  logic [31:0] sampleL = '0;
  logic [31:0] sampleR = '0;
  logic        sampleValid = 1'b0;
  logic        sampleReady, sdataOut, underrunFlag, shortFlag;

  int vecCnt = 0;
  int errCnt = 0;
  bit done = 1'b0;

  logic [31:0] expL = '0, expR = '0, pendL = '0, pendR = '0;
  bit          pendB = 1'b0, expUnder = 1'b0, expShort = 1'b0;

  always #5 clk = ~clk;

  aud_tx_top dut_i (
    .clk(clk), .rstN(rstN), .cfgFmt(cfgFmt), .cfgWlen(cfgWlen),
    .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sampleL(sampleL), .sampleR(sampleR),
    .sampleValid(sampleValid), .sampleReady(sampleReady), .sdataOut(sdataOut),
    .underrunFlag(underrunFlag), .shortFlag(shortFlag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int wl(input int code);
    return (code == 0) ? 16 : (code == 1) ? 20 : (code == 2) ? 24 : 32;
  endfunction

  function automatic string tagOf(input int fmt, input int code);
    case (fmt)
      0: return "R3/R8";
      1: return "R4/R8";
      2: return (code == 3) ? "R9" : "R5/R8";
      3: return "R7/R8";
      default: return "R6/R8";
    endcase
  endfunction

  // expected serial bit from the requirements
  function automatic logic expBit(input int fmt, input int w, input int k, input logic lr,
                                  input int half, input logic [31:0] l, input logic [31:0] r);
    int off;
    int j;
    if (fmt <= 2) begin
      if (fmt == 2 && w == 32) return 1'b0;
      off = (fmt == 0) ? 0 : (fmt == 1) ? 1 : half - w;
      j = k - off;
      if (j < 0 || j >= w) return 1'b0;
      return lr ? l[w-1-j] : r[w-1-j];
    end
    off = (fmt == 3) ? 1 : 0;
    j = k - off;
    if (j < 0 || j >= 2*w) return 1'b0;
    return (j < w) ? l[w-1-j] : r[2*w-1-j];
  endfunction

  task automatic doReset(input int fmt, input int code);
    @(negedge clk);
    rstN = 1'b0; bclkIn = 1'b1; lrclkIn = 1'b0; sampleValid = 1'b0;
    cfgFmt = 3'(fmt); cfgWlen = 2'(code);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    pendB = 1'b0; expUnder = 1'b0; expShort = 1'b0; expL = '0; expR = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pushPair(input logic [31:0] l, input logic [31:0] r);
    check("R2 ready before load", sampleReady, 1'b1);
    sampleL = l; sampleR = r; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    check("R2 ready drops after load", sampleReady, 1'b0);
    pendL = l; pendR = r; pendB = 1'b1;
  endtask

  // one bit-clock period: falling edge with new lrclk, low phase, high phase
  task automatic tick(input logic lr, input bit chk, input logic exp, input string tag,
                      input bit push);
    logic held;
    @(negedge clk);
    bclkIn = 1'b0; lrclkIn = lr;
    if (push) begin
      repeat (4) @(negedge clk);
      pushPair($urandom, $urandom);
    end else begin
      repeat (5) @(negedge clk);
    end
    @(negedge clk);
    held = sdataOut;
    if (chk) check(tag, sdataOut, exp);
    bclkIn = 1'b1;
    repeat (3) @(negedge clk);
    if (chk) check("R12 stable while bit clock high", sdataOut, held);
    repeat (2) @(negedge clk);
  endtask

  task automatic frameStart();
    if (pendB) begin
      expL = pendL; expR = pendR; pendB = 1'b0;
    end else begin
      expUnder = 1'b1;
    end
  endtask

  task automatic checkFlags();
    check("R10 underrun flag", underrunFlag, expUnder);
    check("R11 short flag", shortFlag, expShort);
  endtask

  task automatic runStereo(input int half, input bit chk, input bit push);
    int fmt = int'(cfgFmt);
    int w = wl(int'(cfgWlen));
    string tag = tagOf(fmt, int'(cfgWlen));
    frameStart();
    for (int k = 0; k < half; k++)
      tick(1'b1, chk, expBit(fmt, w, k, 1'b1, half, expL, expR), tag, push && k == 1);
    for (int k = 0; k < half; k++)
      tick(1'b0, chk, expBit(fmt, w, k, 1'b0, half, expL, expR), tag, 1'b0);
    if (chk) checkFlags();
  endtask

  task automatic runDsp(input int len, input bit chk, input bit push);
    int fmt = int'(cfgFmt);
    int w = wl(int'(cfgWlen));
    string tag = tagOf(fmt, int'(cfgWlen));
    frameStart();
    for (int k = 0; k < len; k++)
      tick(k == 0, chk, expBit(fmt, w, k, 1'b0, 0, expL, expR), tag, push && k == 1);
    if (chk) checkFlags();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    doReset(0, 0);
    check("R1 sdata after reset", sdataOut, 1'b0);
    check("R1 ready after reset", sampleReady, 1'b1);
    check("R1 underrun after reset", underrunFlag, 1'b0);
    check("R1 short after reset", shortFlag, 1'b0);

    // stereo framings, all word lengths (R3 R4 R5 R8 R9 R2)
    pushPair($urandom, $urandom);
    for (int f = 0; f < 3; f++) begin
      for (int c = 0; c < 4; c++) begin
        int half = 32 + int'($urandom % 5);
        @(negedge clk);
        cfgFmt = 3'(f); cfgWlen = 2'(c);
        runStereo(half, 1'b0, 1'b1);
        runStereo(half, 1'b1, 1'b1);
        runStereo(half, 1'b1, 1'b1);
      end
    end

    // DSP framings (R6 R7)
    doReset(3, 0);
    pushPair($urandom, $urandom);
    for (int f = 3; f < 5; f++) begin
      for (int c = 0; c < 4; c++) begin
        int len = 64 + int'($urandom % 9);
        @(negedge clk);
        cfgFmt = 3'(f); cfgWlen = 2'(c);
        runDsp(len, 1'b0, 1'b1);
        runDsp(len, 1'b1, 1'b1);
        runDsp(len, 1'b1, 1'b1);
      end
    end

    // R10: a frame with no fresh pair repeats the previous one
    doReset(0, 2);
    pushPair(32'h00A5_C3F1, 32'h005A_3C1E);
    runStereo(28, 1'b1, 1'b1);
    runStereo(28, 1'b1, 1'b0);
    runStereo(28, 1'b1, 1'b1);

    // R11: stereo level shorter than the word length
    doReset(0, 2);
    pushPair($urandom, $urandom);
    runStereo(30, 1'b1, 1'b1);
    expShort = 1'b1;
    runStereo(20, 1'b1, 1'b1);

    // R11: DSP frame shorter than two words, seen at the next frame start
    doReset(4, 0);
    pushPair($urandom, $urandom);
    runDsp(40, 1'b1, 1'b1);
    runDsp(20, 1'b1, 1'b1);
    expShort = 1'b1;
    runDsp(40, 1'b1, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vecCnt++;
      errCnt++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

endmodule